// File: doc/BRIEF.md
# Ternary-Weight Dot-Product Element with Zero Skipping

This block computes the dot product of a vector of signed fixed-point activations with a vector of ternary weights. Each weight takes one of three values: zero, plus one or minus one. No multiplier is used. A plus-one weight adds the activation to the running sum. A minus-one weight adds the two's-complement negation of the activation. A zero weight is never sent to the arithmetic unit at all, so it costs no compute cycle.

Input arrives as groups of `LANES` weight/activation pairs on a valid/ready stream, and a flag marks the final group of a vector. The group is held in a pending register. A lowest-lane-first selector then feeds one non-zero pair per cycle into a single add/subtract unit. A group with no non-zero weights passes through in one cycle and leaves the sum unchanged. When the final pair of the last group has been added, the total is registered onto a valid/ready output and the accumulator restarts from zero for the next vector.

Top module: `ternary_mac_pe`

## Requirements
- R1: Lane i of a group uses weight bits `in_wgt[2i+1:2i]` and activation bits `in_act[i*ACT_W +: ACT_W]`. Weight bit 2i+1 set means the weight is zero, whatever bit 2i holds. With bit 2i+1 clear, bit 2i clear means +1 and bit 2i set means -1.
- R2: A pair whose weight is zero never changes the sum, whatever its activation. A group whose weights are all zero occupies the pending register for exactly one cycle.
- R3: A pair with a +1 weight adds its activation, sign-extended, to the sum.
- R4: A pair with a -1 weight adds the two's-complement negation of its activation. The most negative activation therefore contributes +2^(ACT_W-1).
- R5: The output sum is ACT_W + clog2(MAX_LEN) + 1 bits wide. A vector of MAX_LEN pairs, each contributing ±2^(ACT_W-1), is reported exactly.
- R6: At most one non-zero pair is added per cycle. When the output is free, a group with k non-zero weights is followed by the next group being accepted max(k,1) cycles after its own acceptance.
- R7: One cycle after the final non-zero pair of a last-flagged group is added, `out_valid` rises carrying the full sum of the vector. The next vector starts again from zero.
- R8: While `out_valid` is high and `out_ready` is low, `out_sum` holds its value. A last-flagged group that would complete stays pending, and `in_ready` stays low until the output is taken.
- R9: A synchronous active-high reset clears the sum, empties the pending group and lowers `out_valid`. After reset `in_ready` is high and a partially summed vector is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Group offered |
| in_ready | output | 1 | Group accepted on this cycle when valid |
| in_wgt | input | 2*LANES | Packed ternary weights, two bits per lane |
| in_act | input | ACT_W*LANES | Packed signed activations |
| in_last | input | 1 | Group closes the vector |
| out_valid | output | 1 | Sum available |
| out_ready | input | 1 | Consumer takes the sum |
| out_sum | output | ACT_W+clog2(MAX_LEN)+1 | Signed dot-product result |

## Verification
Single-group vectors with all +1 weights and all -1 weights separate the add path from the negate path, and the most negative activation probes the negation corner. Groups that mix both zero codes with non-zero activations show whether a dropped lane leaks into the sum, and an all-zero vector must produce 0. A run of groups with 3, 0, 4 and 1 non-zero weights measures the acceptance spacing, which tells true zero skipping apart from a fixed per-lane schedule. Full-length vectors of extreme values, back-to-back vectors, a held-off output and a reset in mid-vector cover the width, clearing and stall rules.

// File: rtl/tmac_pkg.sv
package tmac_pkg;
  // Bit positions inside each two-bit ternary weight code
  localparam int WGT_ZERO_BIT = 1;
  localparam int WGT_NEG_BIT  = 0;
  localparam int WGT_BITS     = 2;
endpackage

// File: rtl/tmac_pick.sv
// Lowest-lane-first selector over the lanes still waiting to be added
module tmac_pick #(
  parameter  int LANES = 4,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0] mask,
  output logic [LANES-1:0] grant,
  output logic [IDX_W-1:0] idx,
  output logic             any,
  output logic             at_most_one
);
  logic found;

  always_comb begin
    grant = '0;
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (mask[i] && !found) begin
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
        found    = 1'b1;
      end
    end
  end

  assign any         = |mask;
  assign at_most_one = ((mask & (mask - LANES'(1))) == '0);
endmodule

// File: rtl/tmac_operand.sv
// Sign extension and conditional two's-complement negation; no multiplier
module tmac_operand #(
  parameter int ACT_W = 8,
  parameter int ACC_W = 17
) (
  input  logic [ACT_W-1:0]        act,
  input  logic                    neg,
  input  logic                    en,
  output logic signed [ACC_W-1:0] opnd
);
  logic signed [ACC_W-1:0] ext;

  assign ext = {{(ACC_W-ACT_W){act[ACT_W-1]}}, act};

  always_comb begin
    if (!en)      opnd = '0;
    else if (neg) opnd = ~ext + ACC_W'(1);
    else          opnd = ext;
  end
endmodule

// File: rtl/ternary_mac_pe.sv
module ternary_mac_pe
  import tmac_pkg::*;
#(
  parameter  int ACT_W   = 8,
  parameter  int LANES   = 4,
  parameter  int MAX_LEN = 256,
  localparam int LEN_W   = $clog2(MAX_LEN),
  localparam int ACC_W   = ACT_W + LEN_W + 1,
  localparam int IDX_W   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [WGT_BITS*LANES-1:0] in_wgt,
  input  logic [ACT_W*LANES-1:0]    in_act,
  input  logic                      in_last,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [ACC_W-1:0]          out_sum
);
  // Decoded view of the incoming group
  logic [LANES-1:0] in_nz, in_neg;

  for (genvar g = 0; g < LANES; g++) begin : g_dec
    assign in_nz[g]  = !in_wgt[WGT_BITS*g + WGT_ZERO_BIT];
    assign in_neg[g] = in_wgt[WGT_BITS*g + WGT_NEG_BIT];
  end

  // Pending group
  logic                   pend_v, pend_last;
  logic [LANES-1:0]       pend_mask, pend_neg;
  logic [ACT_W*LANES-1:0] pend_act;

  logic [LANES-1:0] grant;
  logic [IDX_W-1:0] idx;
  logic             has_any, one_left;

  tmac_pick #(.LANES(LANES)) u_pick (
    .mask        (pend_mask),
    .grant       (grant),
    .idx         (idx),
    .any         (has_any),
    .at_most_one (one_left)
  );

  logic final_step, out_free, adv, issue, load;

  assign final_step = pend_v && one_left;
  assign out_free   = !out_valid || out_ready;
  assign adv        = pend_v && !(final_step && pend_last && !out_free);
  assign issue      = adv && has_any;
  assign in_ready   = !pend_v || (final_step && adv);
  assign load       = in_valid && in_ready;

  logic signed [ACC_W-1:0] opnd, acc, sum_next;

  tmac_operand #(.ACT_W(ACT_W), .ACC_W(ACC_W)) u_opnd (
    .act  (pend_act[idx*ACT_W +: ACT_W]),
    .neg  (pend_neg[idx]),
    .en   (issue),
    .opnd (opnd)
  );

  assign sum_next = acc + opnd;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v    <= 1'b0;
      pend_last <= 1'b0;
      pend_mask <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (adv) begin
        pend_mask <= pend_mask & ~grant;
        if (final_step && pend_last) begin
          out_sum   <= sum_next;
          out_valid <= 1'b1;
          acc       <= '0;
        end else if (issue) begin
          acc <= sum_next;
        end
      end
      if (load) begin
        pend_v    <= 1'b1;
        pend_mask <= in_nz;
        pend_neg  <= in_neg;
        pend_act  <= in_act;
        pend_last <= in_last;
      end else if (adv && final_step) begin
        pend_v <= 1'b0;
      end
    end
  end

  // Holding two or more live lanes blocks new input (R6)
  p_in_hold_r6: assert property (@(posedge clk) disable iff (rst)
    pend_v && !one_left |-> !in_ready);

  // Each add retires exactly one live lane; zero lanes never take a slot (R2)
  p_skip_r2: assert property (@(posedge clk) disable iff (rst)
    issue && !load |=> $countones(pend_mask) == $countones($past(pend_mask)) - 1);

  // A sum leaves only with the accumulator already cleared (R7)
  p_acc_clear_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> acc == '0);

  // Stalled result stays put (R8)
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_sum));

  // Completing last group cannot slip past a busy output (R8)
  p_stall_r8: assert property (@(posedge clk) disable iff (rst)
    final_step && pend_last && out_valid && !out_ready |-> !in_ready);
endmodule

// File: tb/ternary_mac_pe_tb.sv
module ternary_mac_pe_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ACT_W   = 8;
  localparam int LANES   = 4;
  localparam int MAX_LEN = 256;
  localparam int ACC_W   = ACT_W + $clog2(MAX_LEN) + 1;

  logic clk = 1'b0;
  logic rst, in_valid, in_ready, in_last, out_valid, out_ready;
  logic [2*LANES-1:0]     in_wgt;
  logic [ACT_W*LANES-1:0] in_act;
  logic [ACC_W-1:0]       out_sum;

  ternary_mac_pe #(.ACT_W(ACT_W), .LANES(LANES), .MAX_LEN(MAX_LEN)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_wgt(in_wgt), .in_act(in_act), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_sum(out_sum));

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0, fails = 0, vec_acc = 0;
  int    exp_q[$];
  string cur_req = "R3";

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  function automatic logic [ACT_W*LANES-1:0] pack(input int a0, input int a1, input int a2, input int a3);
    return {ACT_W'(a3), ACT_W'(a2), ACT_W'(a1), ACT_W'(a0)};
  endfunction

  // Driver: model the contribution, push expected sum, offer group until accepted
  task automatic send(input logic [2*LANES-1:0] w, input logic [ACT_W*LANES-1:0] a,
                      input bit last, output int waited);
    bit ok;
    for (int i = 0; i < LANES; i++) begin
      int v;
      v = int'($signed(a[i*ACT_W +: ACT_W]));
      if (!w[2*i+1]) vec_acc += w[2*i] ? -v : v;
    end
    if (last) begin
      exp_q.push_back(vec_acc);
      vec_acc = 0;
    end
    @(negedge clk); #1;
    in_valid = 1'b1; in_wgt = w; in_act = a; in_last = last;
    waited = 0;
    forever begin
      waited++;
      ok = in_ready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk); #1;
    end
  endtask

  task automatic go_idle();
    @(negedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    go_idle();
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, cur_req, exp_q.size(), 0);
  endtask

  // Monitor / scoreboard
  bit               hold_seen = 1'b0;
  logic [ACC_W-1:0] held;
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      if (hold_seen) check(out_valid && out_sum == held, "R8", int'($signed(out_sum)), int'($signed(held)));
      hold_seen = out_valid && !out_ready;
      held      = out_sum;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R7", int'($signed(out_sum)), 0);
        else begin
          int e;
          e = exp_q.pop_front();
          check(int'($signed(out_sum)) == e, cur_req, int'($signed(out_sum)), e);
        end
      end
    end else hold_seen = 1'b0;
  end

  initial begin
    int w;
    rst = 1'b1; in_valid = 1'b0; in_wgt = '0; in_act = '0; in_last = 1'b0; out_ready = 1'b1;
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check(out_valid == 1'b0, "R9", out_valid, 0);
        check(in_ready == 1'b1, "R9", in_ready, 1);

        // R3: all +1 weights
        cur_req = "R3";
        send(8'h00, pack(5, -3, 100, -128), 1'b1, w);
        drain();

        // R4: all -1 weights, including the most negative activation
        cur_req = "R4";
        send(8'h55, pack(-128, 1, -1, 127), 1'b1, w);
        drain();

        // R1: both zero codes with live activations; lanes = 11,00,10,01
        cur_req = "R1";
        send(8'h63, pack(77, 9, -50, 4), 1'b1, w);
        drain();
        // R2: all-zero vector yields 0
        cur_req = "R2";
        send(8'hAA, pack(11, 22, 33, 44), 1'b1, w);
        drain();

        // R6: spacing follows the non-zero count of the previous group
        cur_req = "R6";
        send(8'h80, pack(1, 2, 3, 4), 1'b0, w);
        check(w == 1, "R6", w, 1);
        send(8'hAA, pack(9, 9, 9, 9), 1'b0, w);
        check(w == 3, "R6", w, 3);
        send(8'h00, pack(-1, -2, -3, -4), 1'b0, w);
        check(w == 1, "R6 R2", w, 1);
        send(8'hA8, pack(60, 5, 5, 5), 1'b0, w);
        check(w == 4, "R6", w, 4);
        send(8'hAA, pack(1, 1, 1, 1), 1'b1, w);
        check(w == 1, "R6", w, 1);
        drain();

        // R7: back-to-back vectors, second must start from zero
        cur_req = "R7";
        send(8'h00, pack(10, 20, 30, 40), 1'b0, w);
        send(8'h05, pack(3, 3, 3, 3), 1'b1, w);
        send(8'h50, pack(-7, 8, 100, 1), 1'b1, w);
        drain();

        // R5: full-length vectors of extreme contributions
        cur_req = "R5";
        for (int g = 0; g < MAX_LEN/LANES; g++)
          send(8'h55, pack(-128, -128, -128, -128), g == MAX_LEN/LANES - 1, w);
        for (int g = 0; g < MAX_LEN/LANES; g++)
          send(8'h00, pack(-128, -128, -128, -128), g == MAX_LEN/LANES - 1, w);
        drain();

        // R8: held-off output stalls completion of the next vector
        cur_req = "R8";
        @(negedge clk); #1; out_ready = 1'b0;
        send(8'h00, pack(1, 2, 3, 4), 1'b1, w);
        send(8'hA8, pack(7, 50, 50, 50), 1'b1, w);
        go_idle();
        repeat (4) @(negedge clk);
        #1;
        check(in_ready == 1'b0, "R8", in_ready, 0);
        check(out_valid == 1'b1, "R8", out_valid, 1);
        @(negedge clk); #1; out_ready = 1'b1;
        drain();

        // R9: reset in mid-vector discards the partial sum
        cur_req = "R9";
        send(8'h00, pack(50, 50, 50, 50), 1'b0, w);
        go_idle();
        repeat (3) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0; vec_acc = 0;
        send(8'h00, pack(1, 1, 1, 1), 1'b1, w);
        drain();
      end
      begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule